// File: doc/BRIEF.md
# Motion compensation reference window fetch planner

This block turns one motion-compensated partition into the list of reference-frame reads that the interpolation stage needs. The partition (4, 8 or 16 pixels on each axis) is split into 4×4 element blocks. Each element block is visited in turn and given the window the six-tap interpolator reads. That window grows by two pixels before and three pixels after the block, but only on an axis whose motion component has a fractional part. An axis with integer motion gets no margin at all.

Inside one partition, neighbouring windows overlap. The planner requests only the pixels that no earlier element block of the same partition has already fetched. It raises flags that tell the pixel cache which side, left or above, holds the columns or rows to reuse. The result is that a whole partition costs exactly one rectangle of (W+ex)×(H+ey) pixels, where ex and ey are 5 on a filtered axis and 0 otherwise.

Each request names one window row: a signed start column, a signed row and a width. Requests leave on a valid/ready handshake. A one-cycle done pulse follows the last accepted row.

Top module: `mc_fetch_planner`

## Requirements
- R1: Partition size selectors use 2'b00 = 4, 2'b01 = 8, 2'b10 or 2'b11 = 16 pixels. Element blocks are visited in raster order inside the partition: column index fastest, then row index, both starting at 0.
- R2: When mv_x[1:0] is nonzero, the leftmost element column of the partition requests a 9-wide window starting 2 pixels left of the block. When mv_x[1:0] is zero, every request is 4 wide and starts at the block's own columns. The request width is always 4 or 9.
- R3: When mv_y[1:0] is nonzero, the top element row requests 9 window rows starting 2 rows above the block. When mv_y[1:0] is zero, every element block requests exactly its own 4 rows.
- R4: An element block with column index above 0 sets reuse_left and requests only 4 new columns. These start at block column + 3 under fractional horizontal motion and at the block column under integer horizontal motion.
- R5: An element block with row index above 0 sets reuse_up and requests only 4 new rows. These start at block row + 3 under fractional vertical motion and at the block row under integer vertical motion.
- R6: One request is issued per window row, top to bottom. A request held with req_ready low keeps its coordinates, width and flags unchanged.
- R7: The widths accepted over one partition sum to (W + 5·fx)·(H + 5·fy), where fx and fy are 1 for a fractional axis.
- R8: done is high for exactly one cycle, the cycle after the last request of a partition is accepted. In that cycle req_valid and busy are low.
- R9: start is taken only while busy is low. A start while busy leaves the request stream of the running partition unchanged.
- R10: The integer motion offset is the motion vector shifted right arithmetically by 2 (floor), so negative vectors move the window left or up, and request coordinates may be negative.
- R11: After reset, req_valid, busy and done are low. req_valid is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin planning a partition (taken when idle) |
| part_w_sel | input | 2 | Partition width code |
| part_h_sel | input | 2 | Partition height code |
| pos_x | input | POS_W | Partition left column, integer pixels |
| pos_y | input | POS_W | Partition top row, integer pixels |
| mv_x | input | MV_W | Horizontal motion, signed quarter-pel |
| mv_y | input | MV_W | Vertical motion, signed quarter-pel |
| req_valid | output | 1 | A row request is presented |
| req_ready | input | 1 | Consumer accepts the request this cycle |
| req_x | output | CW | Signed first column of the row request |
| req_y | output | CW | Signed row of the request |
| req_w | output | 4 | Number of pixels in the row request |
| reuse_left | output | 1 | Columns left of the request come from the cache |
| reuse_up | output | 1 | Rows above the request come from the cache |
| busy | output | 1 | A partition is being planned |
| done | output | 1 | One-cycle pulse after the last accepted row |

## Verification
The bench builds the planner with POS_W = 10 and MV_W = 10. With these values a partition at the frame origin can be combined with negative motion vectors, so signed request coordinates below zero and the floor behaviour of the arithmetic shift become reachable. Every pairing of width and height codes, including the aliased 2'b11, is run against all four motion classes under both a steady and an irregular ready pattern. This reaches the 9-row top band, the 4-column reuse strips and long stalls at every element-block boundary.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  // Element blocks along one partition axis for a size code.
  function automatic logic [2:0] eb_count(input logic [1:0] sel);
    case (sel)
      2'b00:   eb_count = 3'd1;
      2'b01:   eb_count = 3'd2;
      default: eb_count = 3'd4;
    endcase
  endfunction

  // Pixels fetched along one axis by one element block.
  function automatic logic [3:0] fetch_span(input logic first, input logic frac);
    fetch_span = (first && frac) ? 4'd9 : 4'd4;
  endfunction

  // Filter taps needed before the block on a filtered axis.
  function automatic logic [2:0] lead_margin(input logic frac);
    lead_margin = frac ? 3'd2 : 3'd0;
  endfunction

  // Filter taps needed after the block on a filtered axis.
  function automatic logic [2:0] trail_margin(input logic frac);
    trail_margin = frac ? 3'd3 : 3'd0;
  endfunction

endpackage

// File: rtl/mcf_row_ctr.sv
module mcf_row_ctr #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv,
  input  logic [RW-1:0] limit,
  output logic [RW-1:0] row,
  output logic          last
);
  assign last = (row == limit - RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     row <= '0;
    else if (clear) row <= '0;
    else if (adv)   row <= last ? '0 : row + RW'(1);
  end
endmodule

// File: rtl/mcf_blk_seq.sv
module mcf_blk_seq #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [IW-1:0] ncol,
  input  logic [IW-1:0] nrow,
  output logic [IW-1:0] col,
  output logic [IW-1:0] rowb,
  output logic          last_blk
);
  logic col_end;
  assign col_end  = (col == ncol - IW'(1));
  assign last_blk = col_end && (rowb == nrow - IW'(1));

  // Raster walk: column fastest, then next element row.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col  <= '0;
      rowb <= '0;
    end else if (clear) begin
      col  <= '0;
      rowb <= '0;
    end else if (step) begin
      if (col_end) begin
        col  <= '0;
        rowb <= last_blk ? '0 : rowb + IW'(1);
      end else begin
        col <= col + IW'(1);
      end
    end
  end
endmodule

// File: rtl/mcf_axis_win.sv
module mcf_axis_win
  import mcf_pkg::*;
#(
  parameter int CW = 14,
  parameter int IW = 3
) (
  input  logic signed [CW-1:0] origin,
  input  logic [IW-1:0]        idx,
  input  logic                 frac,
  output logic signed [CW-1:0] first,
  output logic [3:0]           span,
  output logic                 reused
);
  logic signed [CW-1:0] blk_off;

  assign reused  = (idx != '0);
  assign span    = fetch_span(!reused, frac);
  assign blk_off = $signed({{(CW-IW-2){1'b0}}, idx, 2'b00});

  // First block starts at the leading taps; later blocks start past
  // the trailing taps already covered by the neighbour.
  always_comb begin
    if (reused) first = origin + blk_off + $signed({{(CW-3){1'b0}}, trail_margin(frac)});
    else        first = origin + blk_off - $signed({{(CW-3){1'b0}}, lead_margin(frac)});
  end
endmodule

// File: rtl/mc_fetch_planner.sv
module mc_fetch_planner
  import mcf_pkg::*;
#(
  parameter  int POS_W = 12,
  parameter  int MV_W  = 12,
  localparam int CW    = POS_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           part_w_sel,
  input  logic [1:0]           part_h_sel,
  input  logic [POS_W-1:0]     pos_x,
  input  logic [POS_W-1:0]     pos_y,
  input  logic signed [MV_W-1:0] mv_x,
  input  logic signed [MV_W-1:0] mv_y,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic signed [CW-1:0] req_x,
  output logic signed [CW-1:0] req_y,
  output logic [3:0]           req_w,
  output logic                 reuse_left,
  output logic                 reuse_up,
  output logic                 busy,
  output logic                 done
);
  localparam int IW = 3;
  localparam int RW = 4;

  // Integer-pel origin: position plus floor(mv / 4).
  function automatic logic signed [CW-1:0] int_origin(
      input logic [POS_W-1:0] pos, input logic signed [MV_W-1:0] mv);
    logic signed [MV_W-1:0] whole;
    whole = mv >>> 2;
    int_origin = $signed({2'b00, pos}) + CW'(whole);
  endfunction

  logic                 busy_q, done_q, fx_q, fy_q;
  logic signed [CW-1:0] org_x_q, org_y_q;
  logic [IW-1:0]        ncol_q, nrow_q;

  // Named internal events for the checker.
  logic          take_start, fire, blk_step, part_end;
  logic [IW-1:0] col, rowb;
  logic          last_blk;
  logic [RW-1:0] row, row_limit;
  logic          row_last;
  logic signed [CW-1:0] x_first, y_first;
  logic [3:0]    x_span, y_span;
  logic          x_reused, y_reused;

  assign take_start = start && !busy_q;
  assign fire       = req_valid && req_ready;
  assign blk_step   = fire && row_last;
  assign part_end   = blk_step && last_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fx_q    <= 1'b0;
      fy_q    <= 1'b0;
      org_x_q <= '0;
      org_y_q <= '0;
      ncol_q  <= IW'(1);
      nrow_q  <= IW'(1);
    end else begin
      done_q <= part_end;
      if (take_start) begin
        busy_q  <= 1'b1;
        fx_q    <= (mv_x[1:0] != 2'b00);
        fy_q    <= (mv_y[1:0] != 2'b00);
        org_x_q <= int_origin(pos_x, mv_x);
        org_y_q <= int_origin(pos_y, mv_y);
        ncol_q  <= eb_count(part_w_sel);
        nrow_q  <= eb_count(part_h_sel);
      end else if (part_end) begin
        busy_q <= 1'b0;
      end
    end
  end

  mcf_blk_seq #(.IW(IW)) u_blk (
    .clk(clk), .rst_n(rst_n), .clear(take_start), .step(blk_step),
    .ncol(ncol_q), .nrow(nrow_q), .col(col), .rowb(rowb), .last_blk(last_blk)
  );

  mcf_axis_win #(.CW(CW), .IW(IW)) u_xwin (
    .origin(org_x_q), .idx(col), .frac(fx_q),
    .first(x_first), .span(x_span), .reused(x_reused)
  );

  mcf_axis_win #(.CW(CW), .IW(IW)) u_ywin (
    .origin(org_y_q), .idx(rowb), .frac(fy_q),
    .first(y_first), .span(y_span), .reused(y_reused)
  );

  assign row_limit = y_span;

  mcf_row_ctr #(.RW(RW)) u_row (
    .clk(clk), .rst_n(rst_n), .clear(take_start), .adv(fire),
    .limit(row_limit), .row(row), .last(row_last)
  );

  assign req_valid  = busy_q;
  assign req_x      = x_first;
  assign req_y      = y_first + $signed({{(CW-RW){1'b0}}, row});
  assign req_w      = x_span;
  assign reuse_left = x_reused;
  assign reuse_up   = y_reused;
  assign busy       = busy_q;
  assign done       = done_q;
endmodule

// File: rtl/mcf_chk.sv
module mcf_chk #(
  parameter int CW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [CW-1:0] req_x,
  input logic [CW-1:0] req_y,
  input logic [3:0]    req_w,
  input logic          reuse_left,
  input logic          reuse_up,
  input logic          busy,
  input logic          done,
  input logic          part_end
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_x) && $stable(req_y)
      && $stable(req_w) && $stable(reuse_left) && $stable(reuse_up));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid && !busy);

  // R8
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid && req_ready));

  // R8
  end_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    part_end |=> done);

  // R2
  width_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_w == 4'd4 || req_w == 4'd9));

  // R4
  left_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && reuse_left |-> req_w == 4'd4);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
endmodule

bind mc_fetch_planner mcf_chk #(.CW(CW)) u_mcf_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_x(req_x), .req_y(req_y), .req_w(req_w), .reuse_left(reuse_left),
  .reuse_up(reuse_up), .busy(busy), .done(done), .part_end(part_end)
);

// File: tb/mc_fetch_planner_bench.sv
module mc_fetch_planner_bench;
  localparam int PERIOD = 10;
  localparam int POS_W  = 10;
  localparam int MV_W   = 10;
  localparam int CW     = POS_W + 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, req_ready = 1'b0;
  logic [1:0] part_w_sel = '0, part_h_sel = '0;
  logic [POS_W-1:0] pos_x = '0, pos_y = '0;
  logic signed [MV_W-1:0] mv_x = '0, mv_y = '0;
  logic req_valid, reuse_left, reuse_up, busy, done;
  logic signed [CW-1:0] req_x, req_y;
  logic [3:0] req_w;

  always #(PERIOD/2) clk = ~clk;

  mc_fetch_planner #(.POS_W(POS_W), .MV_W(MV_W)) u_mc_fetch_planner (
    .clk(clk), .rst_n(rst_n), .start(start), .part_w_sel(part_w_sel),
    .part_h_sel(part_h_sel), .pos_x(pos_x), .pos_y(pos_y), .mv_x(mv_x),
    .mv_y(mv_y), .req_valid(req_valid), .req_ready(req_ready), .req_x(req_x),
    .req_y(req_y), .req_w(req_w), .reuse_left(reuse_left), .reuse_up(reuse_up),
    .busy(busy), .done(done)
  );

  int n_checks = 0, n_fails = 0;
  int qx[$], qy[$], qw[$], ql[$], qu[$];
  bit exp_done = 0, armed = 0, steady = 1;
  int runs_seen = 0, pix = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int size_of(input int sel);
    return (sel == 0) ? 4 : (sel == 1) ? 8 : 16;
  endfunction

  // Behavioural plan: what the consumer must see for one partition.
  task automatic plan(input int ws, input int hs, input int px, input int py,
                      input int mvx, input int mvy);
    int fx = ((mvx % 4) != 0);
    int fy = ((mvy % 4) != 0);
    int ox = px + (mvx >>> 2);
    int oy = py + (mvy >>> 2);
    for (int j = 0; j < size_of(hs) / 4; j++)
      for (int i = 0; i < size_of(ws) / 4; i++) begin
        int xs = (i == 0) ? ox - 2 * fx : ox + 4 * i + 3 * fx;
        int w  = (i == 0 && fx != 0) ? 9 : 4;
        int ys = (j == 0) ? oy - 2 * fy : oy + 4 * j + 3 * fy;
        int h  = (j == 0 && fy != 0) ? 9 : 4;
        for (int r = 0; r < h; r++) begin
          qx.push_back(xs); qy.push_back(ys + r); qw.push_back(w);
          ql.push_back(i > 0); qu.push_back(j > 0);
        end
      end
  endtask

  // Cycle-by-cycle comparison against the planned stream.
  always @(negedge clk) begin
    if (armed) begin
      if (exp_done) begin
        chk(done && !req_valid && !busy, "R8 done pulse", done, 1);
        exp_done = 0;
        runs_seen++;
      end else if (done) begin
        chk(0, "R8 stray done", 1, 0);
      end
      if (req_valid) begin
        if (qx.size() == 0) begin
          chk(0, "R6 extra request", 1, 0);
        end else begin
          chk(int'(req_x) == qx[0], "R2/R4/R10 req_x", int'(req_x), qx[0]);
          chk(int'(req_y) == qy[0], "R3/R5/R6 req_y", int'(req_y), qy[0]);
          chk(int'(req_w) == qw[0], "R2/R4 req_w", int'(req_w), qw[0]);
          chk(int'(reuse_left) == ql[0], "R4 reuse_left", reuse_left, ql[0]);
          chk(int'(reuse_up) == qu[0], "R5 reuse_up", reuse_up, qu[0]);
        end
      end
      req_ready = steady ? 1'b1 : (($urandom % 3) != 0);
      if (req_valid && req_ready && qx.size() > 0) begin
        pix += qw[0];
        void'(qx.pop_front()); void'(qy.pop_front()); void'(qw.pop_front());
        void'(ql.pop_front()); void'(qu.pop_front());
        if (qx.size() == 0) exp_done = 1;
      end
    end
  end

  task automatic run(input int ws, input int hs, input int px, input int py,
                     input int mvx, input int mvy);
    int target = runs_seen + 1;
    int fx = ((mvx % 4) != 0);
    int fy = ((mvy % 4) != 0);
    int want = (size_of(ws) + 5 * fx) * (size_of(hs) + 5 * fy);
    pix = 0;
    plan(ws, hs, px, py, mvx, mvy);
    @(negedge clk);
    part_w_sel = 2'(ws); part_h_sel = 2'(hs);
    pos_x = POS_W'(px); pos_y = POS_W'(py);
    mv_x = MV_W'(mvx); mv_y = MV_W'(mvy);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    // R9: a start while busy with other inputs must change nothing.
    start = 1'b1; part_w_sel = 2'b00; pos_x = POS_W'(px + 37); mv_y = MV_W'(mvy + 1);
    @(negedge clk);
    start = 1'b0;
    while (runs_seen < target) @(negedge clk);
    chk(pix == want, "R7 pixel total", pix, want);
    chk(qx.size() == 0, "R9 stream intact", qx.size(), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int mvs_x[4] = '{-7, 8, 5, -12};
    int mvs_y[4] = '{6, -3, -8, 4};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!req_valid && !busy && !done, "R11 reset state", req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    armed = 1;
    for (int pass = 0; pass < 2; pass++) begin
      steady = (pass == 0);
      for (int ws = 0; ws < 4; ws++)
        for (int hs = 0; hs < 4; hs++)
          for (int c = 0; c < 4; c++)
            // R1 sizes incl. alias 2'b11; R10 near-origin negative windows
            run(ws, hs, (c == 3) ? 0 : 64 + 16 * c, (c == 1) ? 0 : 32,
                mvs_x[c], mvs_y[c]);
    end
    repeat (3) @(negedge clk);
    chk(!busy && !req_valid, "R11 idle after runs", busy, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule